// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block produces the T-state timing for the external bus of an 8-bit processor whose low address byte shares pins with the data byte. It runs two kinds of machine cycle. The port write takes three T-states and sends a latched accumulator byte to an 8-bit port. The opcode fetch takes four T-states: three of bus activity that read a byte into an opcode register, and one quiet state for internal work.

The clock runs at twice the T-state rate, so every T-state has a first half and a second half. The caller raises a start request together with a cycle type, an address and an accumulator value. These inputs are latched on the accepting edge and may change freely afterwards. The block drives the address latch enable, the active-low write and read strobes, the memory/port select and the two status lines. It also drives the multiplexed byte with its output enable, and it gives a single-clock done pulse so that a caller can chain one cycle straight after another.

Top module: `busCycleSeq`

## Requirements
- R1: While reset is asserted, and right after it, every output is at the idle level: latch enable 0, both strobes 1, output enable 0, status lines 0, done 0, opcode register 0. A reset in the middle of a cycle returns the block to idle at once.
- R2: In T1 of a port write (cycType = 0), the low byte of addrIn is driven on both addrHi and adOut, and the upper byte of addrIn is not used. adOe is 1, and ale is 1 for the first clock of T1 only.
- R3: During a port write the status is ioM = 1, s1 = 0, s0 = 1, and it stays unchanged in all six clocks of the cycle.
- R4: In a port write, wrN is low for the three clocks that run from the start of T2 to the middle of T3, and high again in the second half of T3. From T2 to the end of the cycle, adOut carries the accumulator byte latched at the start, and adOe is 1.
- R5: A port write lasts exactly six clocks, and done is 1 only in the sixth.
- R6: In T1 of an opcode fetch (cycType = 1), addrHi carries addrIn[15:8], adOut carries addrIn[7:0], and ale is 1 for the first clock only. The status is ioM = 0, s1 = 1, s0 = 1 for the whole cycle.
- R7: In an opcode fetch, adOe drops to 0 at the start of T2 and adOut reads 0. rdN is low for the four clocks of T2 and T3 and returns high in T4.
- R8: The opcode register takes the value of adIn only on the edge that ends T3 of a fetch. Values on adIn at any other time have no effect on it.
- R9: An opcode fetch lasts exactly eight clocks. T4 has no strobe and no driven bus, and done is 1 only in the eighth clock.
- R10: While a cycle is running, start requests and changes to cycType, addrIn and accIn are ignored. A request held in the done clock starts the next cycle's T1 on the very next clock.
- R11: When no cycle is running, adOe = 0, adOut = 0, ale = 0, wrN = rdN = 1, and ioM, s1 and s0 are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the T-state rate |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to begin a machine cycle |
| cycType | input | 1 | 0 = port write, 1 = opcode fetch |
| addrIn | input | 16 | Memory address, or port number in the low byte |
| accIn | input | 8 | Accumulator byte to write |
| adIn | input | 8 | Byte read from the multiplexed bus |
| addrHi | output | 8 | Upper address byte |
| adOut | output | 8 | Multiplexed low address / data byte |
| adOe | output | 1 | Output enable for adOut |
| ale | output | 1 | Address latch enable |
| wrN | output | 1 | Active-low write strobe |
| rdN | output | 1 | Active-low read strobe |
| ioM | output | 1 | 1 for a port cycle, 0 for a memory cycle |
| s1 | output | 1 | Status line 1 |
| s0 | output | 1 | Status line 0 |
| opcode | output | 8 | Last fetched opcode |
| done | output | 1 | One-clock pulse in the final clock of a cycle |

## Verification
The hardest situations to reach are the cycle boundaries: a request that arrives exactly in the done clock, and requests of the other cycle type held high through a running cycle. The stimulus reaches both directly. It keeps startReq high with the opposite cycType and scrambled address and data through every clock except the last, and then checks at the ports that the status, the bus contents and the idle clock after the cycle are unchanged. In a separate run it raises the request in the done clock and expects a fetch T1 on the next clock. For the opcode capture, adIn carries the wanted byte only in the clock before the capture edge and its complement in all other clocks, so any capture on the wrong edge shows up as a different opcode.

// File: rtl/busSeqPkg.sv
package busSeqPkg;
  typedef enum logic [2:0] {TS_IDLE, TS_T1, TS_T2, TS_T3, TS_T4} tState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;       // latch request inputs
    logic driveAddr;  // put low address byte on the bus
    logic driveData;  // put accumulator byte on the bus
    logic capture;    // take the read byte into the opcode register
  } pathCtl_t;

  localparam logic KIND_IOWR  = 1'b0;
  localparam logic KIND_FETCH = 1'b1;
endpackage

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busSeqPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     cycType,
  output pathCtl_t ctl,
  output logic     ale,
  output logic     wrN,
  output logic     rdN,
  output logic     ioM,
  output logic     s1,
  output logic     s0,
  output logic     done
);
  tState_e tState, nextT;
  logic    halfSel;
  logic    kindQ;
  logic    busy, lastT, accept;

  assign busy   = (tState != TS_IDLE);
  assign lastT  = (kindQ == KIND_IOWR  && tState == TS_T3) ||
                  (kindQ == KIND_FETCH && tState == TS_T4);
  assign done   = lastT && halfSel;
  assign accept = startReq && (!busy || done);

  always_comb begin
    case (tState)
      TS_T1:   nextT = TS_T2;
      TS_T2:   nextT = TS_T3;
      TS_T3:   nextT = (kindQ == KIND_FETCH) ? TS_T4 : TS_IDLE;
      default: nextT = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tState  <= TS_IDLE;
      halfSel <= 1'b0;
      kindQ   <= KIND_IOWR;
    end else if (accept) begin
      tState  <= TS_T1;
      halfSel <= 1'b0;
      kindQ   <= cycType;
    end else if (busy) begin
      halfSel <= ~halfSel;
      if (halfSel) tState <= nextT;
    end
  end

  always_comb begin
    ctl.load      = accept;
    ctl.driveAddr = (tState == TS_T1);
    ctl.driveData = (kindQ == KIND_IOWR) && (tState == TS_T2 || tState == TS_T3);
    ctl.capture   = (kindQ == KIND_FETCH) && (tState == TS_T3) && halfSel;
    ale = (tState == TS_T1) && !halfSel;
    wrN = !((kindQ == KIND_IOWR) &&
            (tState == TS_T2 || (tState == TS_T3 && !halfSel)));
    rdN = !((kindQ == KIND_FETCH) && (tState == TS_T2 || tState == TS_T3));
    ioM = busy && (kindQ == KIND_IOWR);
    s1  = busy && (kindQ == KIND_FETCH);
    s0  = busy;
  end
endmodule

// File: rtl/busSeqPath.sv
module busSeqPath
  import busSeqPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pathCtl_t              ctl,
  input  logic                  cycType,
  input  logic [2*DATA_W-1:0]   addrIn,
  input  logic [DATA_W-1:0]     accIn,
  input  logic [DATA_W-1:0]     adIn,
  output logic [DATA_W-1:0]     addrHi,
  output logic [DATA_W-1:0]     adOut,
  output logic                  adOe,
  output logic [DATA_W-1:0]     opcode
);
  localparam int ADDR_W = 2 * DATA_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] accQ;
  logic [DATA_W-1:0] opQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      accQ  <= '0;
      opQ   <= '0;
    end else begin
      if (ctl.load) begin
        // a port number appears on both halves of the address
        addrQ <= (cycType == KIND_IOWR) ? {addrIn[DATA_W-1:0], addrIn[DATA_W-1:0]}
                                        : addrIn;
        accQ  <= accIn;
      end
      if (ctl.capture) opQ <= adIn;
    end
  end

  assign addrHi = addrQ[ADDR_W-1:DATA_W];
  assign adOe   = ctl.driveAddr | ctl.driveData;
  assign adOut  = ctl.driveAddr ? addrQ[DATA_W-1:0] :
                  ctl.driveData ? accQ : '0;
  assign opcode = opQ;
endmodule

// File: rtl/busCycleSeq.sv
module busCycleSeq
  import busSeqPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic                cycType,
  input  logic [2*DATA_W-1:0] addrIn,
  input  logic [DATA_W-1:0]   accIn,
  input  logic [DATA_W-1:0]   adIn,
  output logic [DATA_W-1:0]   addrHi,
  output logic [DATA_W-1:0]   adOut,
  output logic                adOe,
  output logic                ale,
  output logic                wrN,
  output logic                rdN,
  output logic                ioM,
  output logic                s1,
  output logic                s0,
  output logic [DATA_W-1:0]   opcode,
  output logic                done
);
  pathCtl_t ctl;

  busSeqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cycType(cycType),
    .ctl(ctl), .ale(ale), .wrN(wrN), .rdN(rdN),
    .ioM(ioM), .s1(s1), .s0(s0), .done(done)
  );

  busSeqPath #(.DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cycType(cycType),
    .addrIn(addrIn), .accIn(accIn), .adIn(adIn),
    .addrHi(addrHi), .adOut(adOut), .adOe(adOe), .opcode(opcode)
  );
endmodule

// File: rtl/busCycleSeqChk.sv
module busCycleSeqChk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] addrHi,
  input logic [DATA_W-1:0] adOut,
  input logic              adOe,
  input logic              ale,
  input logic              wrN,
  input logic              rdN,
  input logic              ioM,
  input logic              s1,
  input logic              s0,
  input logic              done
);
  // R2
  ale_one_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);

  // R2
  port_addr_both_halves_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ale && ioM) |-> (adOe && adOut == addrHi));

  // R3
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (s0 && !done) |=> $stable({ioM, s1, s0}));

  // R4
  write_data_driven_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> (adOe && ioM && !s1 && s0 && rdN));

  // R7
  read_bus_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> (!adOe && !ioM && s1 && s0 && wrN));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !s0 |-> (!adOe && !ale && wrN && rdN && !done));
endmodule

bind busCycleSeq busCycleSeqChk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .addrHi(addrHi), .adOut(adOut), .adOe(adOe),
  .ale(ale), .wrN(wrN), .rdN(rdN), .ioM(ioM), .s1(s1), .s0(s0), .done(done)
);

// File: tb/busCycleSeq_bench.sv
module busCycleSeq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        cycType = 1'b0;
  logic [15:0] addrIn = '0;
  logic [7:0]  accIn = '0;
  logic [7:0]  adIn = '0;
  logic [7:0]  addrHi, adOut, opcode;
  logic        adOe, ale, wrN, rdN, ioM, s1, s0, done;

  int nRun = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  busCycleSeq u_busCycleSeq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cycType(cycType),
    .addrIn(addrIn), .accIn(accIn), .adIn(adIn),
    .addrHi(addrHi), .adOut(adOut), .adOe(adOe), .ale(ale),
    .wrN(wrN), .rdN(rdN), .ioM(ioM), .s1(s1), .s0(s0),
    .opcode(opcode), .done(done)
  );

  // {cycType, addrIn, accIn, fetched byte}
  localparam logic [32:0] VECS [6] = '{
    {1'b0, 16'h1234, 8'h5A, 8'h00},
    {1'b0, 16'h00FF, 8'h00, 8'h00},
    {1'b0, 16'hABFE, 8'hFF, 8'h00},
    {1'b1, 16'h2000, 8'h11, 8'h78},
    {1'b1, 16'hFFFF, 8'h22, 8'hC3},
    {1'b1, 16'h0001, 8'h33, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chkIdle(input string tag);
    chk(tag, {24'd0, adOut}, 32'd0);
    chk(tag, {26'd0, adOe, ale, wrN, rdN, ioM, s1}, {26'd0, 6'b001100});
    chk(tag, {30'd0, s0, done}, 32'd0);
  endtask

  task automatic runCycle(input logic typ, input logic [15:0] addr, input logic [7:0] acc,
                          input logic [7:0] opb, input bit poke, input bit preStarted,
                          input bit chainOn, input logic [15:0] chainAddr);
    int n;
    logic [7:0] expHi, expLo;
    n = typ ? 8 : 6;
    expHi = typ ? addr[15:8] : addr[7:0];
    expLo = addr[7:0];
    if (!preStarted) begin
      @(negedge clk);
      startReq = 1'b1; cycType = typ; addrIn = addr; accIn = acc;
    end
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      startReq = poke && (k < n);
      cycType  = ~typ;
      addrIn   = ~addr;
      accIn    = ~acc;
      adIn     = (k == 6) ? opb : ~opb;
      if (chainOn && k == n) begin
        startReq = 1'b1; cycType = 1'b1; addrIn = chainAddr;
      end
      if (!typ) begin
        // R2 R4 R5 port write strobes {ale, wrN, rdN, adOe, done}
        chk("R2 R4 R5 write strobes", {27'd0, ale, wrN, rdN, adOe, done},
            {27'd0, (k == 1), !(k >= 3 && k <= 5), 1'b1, 1'b1, (k == n)});
        chk("R2 R4 write bus", {16'd0, addrHi, adOut},
            {16'd0, expHi, (k <= 2) ? expLo : acc});
        chk("R3 write status", {29'd0, ioM, s1, s0}, 32'd5);
      end else begin
        chk("R6 R7 R9 fetch strobes", {27'd0, ale, wrN, rdN, adOe, done},
            {27'd0, (k == 1), 1'b1, !(k >= 3 && k <= 6), (k <= 2), (k == n)});
        chk("R6 R7 fetch bus", {16'd0, addrHi, adOut},
            {16'd0, expHi, (k <= 2) ? expLo : 8'h00});
        chk("R6 fetch status", {29'd0, ioM, s1, s0}, 32'd3);
      end
    end
    if (typ) chk("R8 opcode capture", {24'd0, opcode}, {24'd0, opb});
  endtask

  initial begin
    #2000000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chkIdle("R1 reset idle");
    chk("R1 reset opcode", {24'd0, opcode}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chkIdle("R1 after reset");

    // table walk
    for (int i = 0; i < 6; i++) begin
      runCycle(VECS[i][32], VECS[i][31:16], VECS[i][15:8], VECS[i][7:0], 1'b0, 1'b0, 1'b0, 16'h0);
      @(negedge clk);
      startReq = 1'b0;
      chkIdle("R11 idle after cycle");
    end

    // R10 requests of the other type held through a port write are ignored
    runCycle(1'b0, 16'h7E42, 8'h96, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0);
    @(negedge clk);
    chkIdle("R10 no start while busy");

    // R10 requests held through a fetch are ignored; R8 opcode unchanged afterwards
    runCycle(1'b1, 16'h4321, 8'h00, 8'hA5, 1'b1, 1'b0, 1'b0, 16'h0);
    @(negedge clk);
    chkIdle("R10 no start while busy fetch");
    adIn = 8'h3C;
    repeat (3) @(negedge clk);
    chk("R8 idle adIn ignored", {24'd0, opcode}, 32'hA5);

    // R10 back-to-back: request in the done clock of a write starts a fetch at once
    runCycle(1'b0, 16'h0099, 8'h66, 8'h00, 1'b0, 1'b0, 1'b1, 16'hBEEF);
    runCycle(1'b1, 16'hBEEF, 8'h00, 8'h5F, 1'b0, 1'b1, 1'b0, 16'h0);
    @(negedge clk);
    chkIdle("R10 R11 idle after chain");

    // R1 reset in the middle of a port write
    @(negedge clk);
    startReq = 1'b1; cycType = 1'b0; addrIn = 16'h0011; accIn = 8'h22;
    repeat (3) @(negedge clk);
    startReq = 1'b0;
    chk("R1 mid-cycle write active", {31'd0, wrN}, 32'd0);
    rstN = 1'b0;
    #1;
    chkIdle("R1 mid-cycle reset");
    chk("R1 mid-cycle reset opcode", {24'd0, opcode}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chkIdle("R1 idle after mid-cycle reset");

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule